// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the internal word address of a pipelined synchronous cache SRAM. On a rising clock edge it can capture a starting address from the external bus, and it then walks the two low-order address bits through a four-beat burst while the upper bits stay fixed. Two active-low start strobes can open a burst. The processor-side strobe is honoured only while the first chip select is active (low). The controller-side strobe is always honoured.

An active-low advance strobe moves the burst one beat forward in any cycle where no start is accepted. A start accepted in the same cycle as an advance takes precedence. A burst-order pin selects between two wrap orders. Interleaved order XORs the start offset with the beat number. Linear order adds the beat number to the start offset modulo four. The pin is sampled when a burst starts and held for the whole burst. The address width is a parameter. A build parameter can also fix the block to a single order.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `word_addr` is all zeros, the beat count is zero and the order is interleaved.
- R2: When `pstart_n` is low and `sel1_n` is low at a rising edge, `word_addr` equals the `addr_in` value sampled at that edge from the following cycle on.
- R3: When `cstart_n` is low at a rising edge, `word_addr` equals the sampled `addr_in` from the following cycle on, whatever the level of `sel1_n`.
- R4: When `sel1_n` is high, a low `pstart_n` has no effect: with `cstart_n` high and `adv_n` high, `word_addr` stays unchanged.
- R5: With no start accepted, a low `adv_n` moves the burst forward by exactly one beat. A high `adv_n` leaves `word_addr` unchanged.
- R6: With `order_lin` low at burst start (interleaved), the two low bits of `word_addr` on beat n are the start offset XOR n.
- R7: With `order_lin` high at burst start (linear), the two low bits of `word_addr` on beat n are (start offset + n) mod 4.
- R8: After the fourth beat, the next advance returns to the start offset. `word_addr[AW-1:2]` never changes except when a start is accepted.
- R9: `order_lin` is sampled only when a start is accepted. Changing it during a burst does not change the sequence.
- R10: An accepted start overrides a simultaneous advance and restarts at beat 0. When both strobes are low with `sel1_n` low, one start at the sampled address results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pstart_n | input | 1 | Processor-side start strobe, active low, gated by `sel1_n` |
| cstart_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance strobe, active low |
| order_lin | input | 1 | Burst order select: 0 interleaved, 1 linear |
| sel1_n | input | 1 | First chip select, active low |
| addr_in | input | AW | External address bus |
| word_addr | output | AW | Internal word address for the current cycle |

## Verification
On every cycle the assertions check the following. Both start paths load the sampled address. A blocked processor strobe and an idle cycle leave the address untouched. An advance steps the beat count by one. The upper bits and the latched order stay constant between starts.

Only the bench's scenarios can show the actual wrap orders. They cover both orders from all four offsets, including the return to the start offset after four beats. The bench also shows that a mid-burst flip of the order pin has no effect, and it covers the simultaneous start-and-advance cases.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   localparam int BEAT_W = 2;
   localparam int BEATS  = 1 << BEAT_W;

   typedef logic [BEAT_W-1:0] beat_t;

   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } order_e;

   // build-time choice of which orders are available
   localparam int ORDER_PIN   = 0;
   localparam int ORDER_ILV   = 1;
   localparam int ORDER_LIN   = 2;

endpackage

// File: rtl/bseq_start_gate.sv
module bseq_start_gate (
   input  logic pstart_n,
   input  logic cstart_n,
   input  logic sel1_n,
   output logic load,
   output logic from_proc
);
   logic proc_ok;
   logic ctrl_ok;

   always_comb begin
      proc_ok   = ~pstart_n & ~sel1_n;
      ctrl_ok   = ~cstart_n;
      // processor path wins when it is not blocked
      from_proc = proc_ok;
      load      = proc_ok | ctrl_ok;
   end
endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg
   import burst_seq_pkg::*;
#(
   parameter int AW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] addr_in,
   input  logic          order_lin,
   output logic [AW-1:BEAT_W] upper_q,
   output beat_t         start_q,
   output order_e        mode_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         start_q <= '0;
         mode_q  <= ORD_INTERLEAVE;
      end else if (load) begin
         upper_q <= addr_in[AW-1:BEAT_W];
         start_q <= addr_in[BEAT_W-1:0];
         mode_q  <= order_lin ? ORD_LINEAR : ORD_INTERLEAVE;
      end
   end
endmodule

// File: rtl/bseq_counter.sv
module bseq_counter
   import burst_seq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  logic  adv_n,
   output beat_t cnt_q
);
   logic  step;
   beat_t cnt_d;

   always_comb begin
      step  = ~adv_n & ~load;
      cnt_d = cnt_q;
      if (load)      cnt_d = '0;
      else if (step) cnt_d = cnt_q + beat_t'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
   import burst_seq_pkg::*;
#(
   parameter int ORDER_MODE = ORDER_PIN
) (
   input  beat_t  start_q,
   input  beat_t  cnt_q,
   input  order_e mode_q,
   output beat_t  low
);
   beat_t ilv;
   beat_t lin;

   always_comb begin
      ilv = start_q ^ cnt_q;
      lin = start_q + cnt_q;
   end

   generate
      if (ORDER_MODE == ORDER_ILV) begin : g_ilv
         assign low = ilv;
      end else if (ORDER_MODE == ORDER_LIN) begin : g_lin
         assign low = lin;
      end else begin : g_pin
         assign low = (mode_q == ORD_LINEAR) ? lin : ilv;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int AW         = 17,
   parameter int ORDER_MODE = ORDER_PIN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pstart_n,
   input  logic          cstart_n,
   input  logic          adv_n,
   input  logic          order_lin,
   input  logic          sel1_n,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] word_addr
);
   localparam int UPPER_W = AW - BEAT_W;

   initial begin
      if (AW <= BEAT_W)
         $error("AW must exceed the beat counter width");
      if (ORDER_MODE < ORDER_PIN || ORDER_MODE > ORDER_LIN)
         $error("ORDER_MODE out of range");
   end

   logic                 load;
   logic                 from_proc;
   logic [AW-1:BEAT_W]   upper_q;
   beat_t                start_q;
   order_e               mode_q;
   beat_t                cnt_q;
   beat_t                low;

   bseq_start_gate u_gate (
      .pstart_n  (pstart_n),
      .cstart_n  (cstart_n),
      .sel1_n    (sel1_n),
      .load      (load),
      .from_proc (from_proc)
   );

   bseq_addr_reg #(.AW(AW)) u_areg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .addr_in   (addr_in),
      .order_lin (order_lin),
      .upper_q   (upper_q),
      .start_q   (start_q),
      .mode_q    (mode_q)
   );

   bseq_counter u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .adv_n (adv_n),
      .cnt_q (cnt_q)
   );

   bseq_order_map #(.ORDER_MODE(ORDER_MODE)) u_map (
      .start_q (start_q),
      .cnt_q   (cnt_q),
      .mode_q  (mode_q),
      .low     (low)
   );

   logic unused_src;
   assign unused_src = from_proc & (UPPER_W > 0);

   assign word_addr = {upper_q, low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int AW = 17
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pstart_n,
   input logic          cstart_n,
   input logic          adv_n,
   input logic          sel1_n,
   input logic [AW-1:0] addr_in,
   input logic [AW-1:0] word_addr,
   input logic [1:0]    cnt_q,
   input logic          mode_q
);
   logic p_take;
   logic c_take;
   assign p_take = ~pstart_n & ~sel1_n;
   assign c_take = ~cstart_n;

   a_r2_proc_load: assert property (@(posedge clk) disable iff (!rst_n)
      p_take |=> word_addr == $past(addr_in));

   a_r3_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      c_take |=> word_addr == $past(addr_in));

   a_r4_proc_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (!pstart_n && sel1_n && cstart_n && adv_n) |=> $stable(word_addr));

   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_take && !c_take && adv_n) |=> $stable(word_addr));

   a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_take && !c_take && !adv_n) |=> cnt_q == 2'($past(cnt_q) + 2'd1));

   a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_take && !c_take) |=> $stable(word_addr[AW-1:2]));

   a_r9_order_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_take && !c_take) |=> $stable(mode_q));

   a_r10_start_beats_adv: assert property (@(posedge clk) disable iff (!rst_n)
      ((p_take || c_take) && !adv_n) |=> cnt_q == 2'd0);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pstart_n  (pstart_n),
   .cstart_n  (cstart_n),
   .adv_n     (adv_n),
   .sel1_n    (sel1_n),
   .addr_in   (addr_in),
   .word_addr (word_addr),
   .cnt_q     (cnt_q),
   .mode_q    (mode_q)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pstart_n = 1'b1;
   logic          cstart_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          order_lin = 1'b0;
   logic          sel1_n = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] word_addr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int m_upper = 0;
   int m_start = 0;
   int m_beat  = 0;
   int m_lin   = 0;

   always #10 clk = ~clk;

   burst_addr_seq #(.AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .pstart_n(pstart_n), .cstart_n(cstart_n),
      .adv_n(adv_n), .order_lin(order_lin), .sel1_n(sel1_n),
      .addr_in(addr_in), .word_addr(word_addr)
   );

   function automatic int model_addr();
      int lo;
      if (m_lin != 0) lo = (m_start + m_beat) % 4;
      else            lo = m_start ^ (m_beat % 4);
      return m_upper * 4 + lo;
   endfunction

   task automatic compare(input string req);
      int exp;
      exp = model_addr();
      checks++;
      if (int'(word_addr) != exp) begin
         errors++;
         $display("FAIL %s: word_addr actual %0h expected %0h", req, word_addr, exp);
      end
   endtask

   // one clock: drive inputs, update model at the edge, compare at negedge
   task automatic cyc(input logic p_n, input logic c_n, input logic a_n,
                      input logic lin, input logic s_n, input int adr,
                      input string req);
      pstart_n = p_n; cstart_n = c_n; adv_n = a_n;
      order_lin = lin; sel1_n = s_n; addr_in = AW'(adr);
      @(posedge clk);
      if ((!p_n && !s_n) || !c_n) begin
         m_upper = adr / 4;
         m_start = adr % 4;
         m_beat  = 0;
         m_lin   = lin ? 1 : 0;
      end else if (!a_n) begin
         m_beat = (m_beat + 1) % 4;
      end
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release");

      // both orders from every start offset, with wrap (R2 R6 R7 R8)
      for (int lin = 0; lin < 2; lin++) begin
         for (int off = 0; off < 4; off++) begin
            int base;
            base = 'h1A5C0 + lin * 'h40 + off;
            base = base % (1 << AW);
            cyc(0, 1, 1, lin[0], 0, base, "R2 proc start");
            for (int b = 0; b < 5; b++)
               cyc(1, 1, 0, lin[0], 0, 'h0BEEF,
                   lin ? "R7 R8 linear beat" : "R6 R8 interleaved beat");
         end
      end

      // controller start with chip select inactive (R3)
      cyc(1, 0, 1, 1, 1, 'h12346, "R3 ctrl start");
      cyc(1, 1, 0, 1, 1, 'h0, "R7 step after ctrl start");
      // processor strobe blocked (R4)
      cyc(0, 1, 1, 0, 1, 'h05551, "R4 proc blocked");
      cyc(0, 1, 1, 1, 1, 'h1FFFF, "R4 proc blocked again");
      // idle hold (R5)
      cyc(1, 1, 1, 0, 0, 'h00003, "R5 hold");
      cyc(1, 1, 0, 0, 0, 'h00003, "R5 step");
      // blocked proc strobe with ctrl strobe still starts (R3)
      cyc(0, 0, 1, 0, 1, 'h0A0A2, "R3 ctrl while proc blocked");
      // order pin flipped mid-burst ignored (R9)
      cyc(0, 1, 1, 0, 0, 'h00031, "R9 start interleaved");
      cyc(1, 1, 0, 1, 0, 'h0, "R9 pin flipped beat1");
      cyc(1, 1, 0, 1, 0, 'h0, "R9 pin flipped beat2");
      cyc(1, 1, 0, 0, 0, 'h0, "R9 beat3");
      // start with advance in same cycle (R10)
      cyc(0, 1, 0, 1, 0, 'h07772, "R10 start over advance");
      cyc(1, 1, 0, 1, 0, 'h0, "R10 next beat");
      cyc(1, 0, 0, 0, 0, 'h11111, "R10 ctrl start over advance");
      // both strobes together (R10)
      cyc(0, 0, 1, 1, 0, 'h02463, "R10 both strobes");
      cyc(1, 1, 0, 1, 0, 'h0, "R10 beat after both");
      cyc(1, 1, 0, 1, 0, 'h0, "R10 beat2 after both");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule